// File: doc/BRIEF.md
# CAN Controller SPI Command Front-End

This block is the host side of a standalone CAN controller. An external processor talks to it as an SPI slave in mode 0, one byte per eight clocks, and each window with chip select low is one transaction whose first byte is an opcode. The front-end keeps the configuration registers that the protocol engine uses. These are a control byte with the operating mode, a second control byte with the transmit enable, an interrupt-enable mask and two bit-timing bytes. It also serves status, interrupt flags, sticky error flags, both error counters and a message-status byte back to the host. The SPI pins are sampled in the system clock domain through two-stage synchronisers, so the serial clock must be well below the system clock.

Received frames are pushed into a small frame store by the engine and drained by the host with a 14-byte streaming read. Frames to send are passed byte by byte to the engine as the host writes them. When chip select rises, the block reports whether the byte count matched the length implied by the frame format and data length. An input from the oscillator start-up logic gates all host access until the clock is stable.

Top module: `can_spi_frontend`

## Requirements
- R1: After reset, control byte 0 reads 0x80 (mode field bits 7:5 = 4, initialisation), the status byte reads 0x82, and control byte 1, interrupt enable, both timing bytes and the error flags read 0x00.
- R2: Write opcodes 0x14, 0x16, 0x1C, 0x18 and 0x1A store the second byte into control 0, control 1, interrupt enable, timing 0 and timing 1. Read opcodes 0xD2, 0xD4, 0xD6 and 0xD8 return control 0, control 1, timing 0 and timing 1. The stored values appear on the cfg outputs.
- R3: A read is two bytes. The value is shifted out MSB first during the second byte, MISO changes after the falling serial clock edge, MOSI is captured on the rising edge, and MISO is 0 while chip select is high.
- R4: The one-byte opcode 0x56 returns control 0 to 0x80, clears control 1, interrupt enable, timing bytes and interrupt flags, and sets transmit-empty. The error flags are kept.
- R5: Error flags are set by ev_err pulses and read with 0xDC. Completing that read clears exactly the bits it returned. A flag set during the read survives.
- R6: Interrupt flags are set by ev_flags, read with 0xDE, and cleared by that read in the same way as the error flags. irq is high while any flag is set whose enable bit is set.
- R7: The status byte (opcode 0xE2) is laid out as follows. Bit 7 is transmit empty, bit 4 is warning (tec or rec at least 96), bit 3 is passive (tec or rec at least 128), bit 2 is bus_off, bit 1 is receive store empty, and the other bits are 0.
- R8: Opcode 0xD4 is not this; opcode 0x48 streams the oldest stored frame as 14 bytes, frame byte k taken from rx_frame[111-8k -: 8]. The frame is removed only when the 14th byte completes, and a read of an empty store returns zeros.
- R9: Opcode 0x12 passes every following byte to txf_valid/txf_data. When chip select rises on a byte boundary, txf_end pulses, transmit-empty clears, and txf_len_ok is high when the byte count equals 4 + min(DLC,8) for a standard frame or 6 + min(DLC,8) for an extended one. The extended marker is bit 3 of payload byte 2, and the DLC is the low nibble of payload byte 3 (standard) or 5 (extended). A tx_sent pulse sets transmit-empty again.
- R10: A chip select rise in the middle of a byte discards that byte. No write, clear-on-read or frame removal results from it.
- R11: An unknown opcode shifts out 0x00 and changes no state.
- R12: While core_ready is low, every transaction is treated as an unknown opcode.
- R13: cfg_tx_en follows bit 7 of control byte 1.
- R14: Opcodes 0xEC, 0xEA and 0xDA return tec, rec and msg_stat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_ready | input | 1 | Oscillator stable, host access allowed |
| spi_sclk | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host to block data |
| spi_miso | output | 1 | Block to host data |
| cfg_ctrl0 | output | 8 | Control byte 0 (mode in bits 7:5) |
| cfg_ctrl1 | output | 8 | Control byte 1 |
| cfg_inte | output | 8 | Interrupt enable mask |
| cfg_btr0 | output | 8 | Bit timing byte 0 |
| cfg_btr1 | output | 8 | Bit timing byte 1 |
| cfg_tx_en | output | 1 | Transmit enable |
| irq | output | 1 | Enabled interrupt pending |
| txf_valid | output | 1 | Transmit byte strobe |
| txf_data | output | 8 | Transmit byte |
| txf_end | output | 1 | Transmit write finished |
| txf_len_ok | output | 1 | Byte count matched the frame format, valid with txf_end |
| tx_sent | input | 1 | Engine finished sending, sets transmit-empty |
| ev_flags | input | 8 | Interrupt flag set pulses |
| ev_err | input | 8 | Error flag set pulses |
| bus_off | input | 1 | Engine is bus-off |
| tec | input | 8 | Transmit error counter |
| rec | input | 8 | Receive error counter |
| msg_stat | input | 8 | Message status byte |
| rx_push | input | 1 | Store rx_frame |
| rx_frame | input | 112 | Received frame, byte 0 in the top bits |
| rx_full | output | 1 | Receive store full, pushes dropped |

## Verification
A corrupted opcode latch or byte index shows on the very next MISO byte of a read, or as a wrong cfg value one clock after the second byte of a write. A wrong clear-on-read mask shows only on the next read of the same register, so every read is repeated. A stale frame-store pointer shows as a repeated or skipped frame on the next 0x48 read and as a wrong bit 1 in status. Partial transactions are followed by full reads to expose hidden side effects.

// File: rtl/can_spi_pkg.sv
package can_spi_pkg;
  localparam int BYTE_W      = 8;
  localparam int FRAME_BYTES = 14;
  localparam int FRAME_BITS  = FRAME_BYTES * BYTE_W;
  localparam int WARN_LVL    = 96;
  localparam int PASSIVE_LVL = 128;

  localparam logic [7:0] OP_MRESET = 8'h56;
  localparam logic [7:0] OP_W_CTL0 = 8'h14;
  localparam logic [7:0] OP_W_CTL1 = 8'h16;
  localparam logic [7:0] OP_W_IEN  = 8'h1C;
  localparam logic [7:0] OP_W_TIM0 = 8'h18;
  localparam logic [7:0] OP_W_TIM1 = 8'h1A;
  localparam logic [7:0] OP_W_TXF  = 8'h12;
  localparam logic [7:0] OP_R_CTL0 = 8'hD2;
  localparam logic [7:0] OP_R_CTL1 = 8'hD4;
  localparam logic [7:0] OP_R_STAT = 8'hE2;
  localparam logic [7:0] OP_R_TIM0 = 8'hD6;
  localparam logic [7:0] OP_R_TIM1 = 8'hD8;
  localparam logic [7:0] OP_R_IFLG = 8'hDE;
  localparam logic [7:0] OP_R_ERR  = 8'hDC;
  localparam logic [7:0] OP_R_MSG  = 8'hDA;
  localparam logic [7:0] OP_R_REC  = 8'hEA;
  localparam logic [7:0] OP_R_TEC  = 8'hEC;
  localparam logic [7:0] OP_R_RXF  = 8'h48;

  localparam logic [7:0] CTL0_INIT = 8'h80;

  function automatic logic [7:0] status_byte(input logic tx_empty, input logic rx_empty,
                                             input logic boff, input logic [7:0] tcnt,
                                             input logic [7:0] rcnt);
    logic warn, pas;
    warn = (int'(tcnt) >= WARN_LVL) || (int'(rcnt) >= WARN_LVL);
    pas  = (int'(tcnt) >= PASSIVE_LVL) || (int'(rcnt) >= PASSIVE_LVL);
    return {tx_empty, 2'b00, warn, pas, boff, rx_empty, 1'b0};
  endfunction

  function automatic logic [4:0] tx_len_expect(input logic ext, input logic [3:0] dlc);
    logic [3:0] d;
    d = (dlc > 4'd8) ? 4'd8 : dlc;
    return (ext ? 5'd6 : 5'd4) + {1'b0, d};
  endfunction

  function automatic logic [7:0] frame_byte(input logic [FRAME_BITS-1:0] f, input logic [3:0] k);
    return f[FRAME_BITS-1-BYTE_W*int'(k) -: BYTE_W];
  endfunction
endpackage

// File: rtl/can_spi_link.sv
module can_spi_link #(
  parameter int W     = 8,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             mosi,
  output logic             miso,
  output logic             cs_stop,
  output logic             cs_clean,
  output logic             byte_done,
  output logic [W-1:0]     rx_byte,
  output logic [IDX_W-1:0] byte_idx,
  input  logic             load_en,
  input  logic [W-1:0]     load_byte
);
  localparam int BC_W = $clog2(W);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [2:0] sclk_p, cs_p;
  logic [1:0] mosi_p;
  logic cs_act, cs_act_d, rise, fall;
  logic [BC_W-1:0] bit_cnt;
  logic [W-1:0] rx_sh, tx_sh;
  logic miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      cs_p   <= {cs_p[1:0], cs_n};
      mosi_p <= {mosi_p[0], mosi};
    end
  end

  assign cs_act    = !cs_p[1];
  assign cs_act_d  = !cs_p[2];
  assign cs_stop   = cs_act_d && !cs_act;
  assign rise      = cs_act && sclk_p[1] && !sclk_p[2];
  assign fall      = cs_act && !sclk_p[1] && sclk_p[2];
  assign byte_done = rise && (bit_cnt == BC_W'(W-1));
  assign rx_byte   = {rx_sh[W-2:0], mosi_p[1]};
  assign cs_clean  = (bit_cnt == '0);
  assign miso      = miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      byte_idx <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      miso_q   <= 1'b0;
    end else if (!cs_act) begin
      bit_cnt  <= '0;
      byte_idx <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      miso_q   <= 1'b0;
    end else begin
      if (rise) begin
        rx_sh   <= rx_byte;
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (byte_done && byte_idx != IDX_MAX) byte_idx <= byte_idx + 1'b1;
      if (load_en) begin
        tx_sh <= load_byte;
      end else if (fall) begin
        miso_q <= tx_sh[W-1];
        tx_sh  <= {tx_sh[W-2:0], 1'b0};
      end
    end
  end

  // R3
  idle_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && !cs_act_d) |-> !miso);
  // R3
  load_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> cs_act);
endmodule

// File: rtl/can_rx_store.sv
module can_rx_store #(
  parameter int DEPTH   = 4,
  parameter int FRAME_W = 112
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [FRAME_W-1:0] din,
  input  logic               pop,
  input  logic               flush,
  output logic [FRAME_W-1:0] head,
  output logic               empty,
  output logic               full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [FRAME_W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // R8
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/can_spi_regs.sv
module can_spi_regs
  import can_spi_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  core_ready,
  input  logic                  byte_done,
  input  logic [7:0]            rx_byte,
  input  logic [IDX_W-1:0]      byte_idx,
  input  logic                  cs_stop,
  input  logic                  cs_clean,
  output logic                  load_en,
  output logic [7:0]            load_byte,
  output logic [7:0]            cfg_ctrl0,
  output logic [7:0]            cfg_ctrl1,
  output logic [7:0]            cfg_inte,
  output logic [7:0]            cfg_btr0,
  output logic [7:0]            cfg_btr1,
  output logic                  irq,
  output logic                  txf_valid,
  output logic [7:0]            txf_data,
  output logic                  txf_end,
  output logic                  txf_len_ok,
  input  logic                  tx_sent,
  input  logic [7:0]            ev_flags,
  input  logic [7:0]            ev_err,
  input  logic                  bus_off,
  input  logic [7:0]            tec,
  input  logic [7:0]            rec,
  input  logic [7:0]            msg_stat,
  input  logic [FRAME_BITS-1:0] rx_head,
  input  logic                  rx_empty,
  output logic                  rx_pop,
  output logic                  mreset_ev
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BYTES);

  logic [7:0] op_q, op_now, rd_snap, read_val;
  logic [7:0] intf_q, err_q, intf_clr, err_clr;
  logic rd_ok, tx_empty_q;
  logic is_first, at_second, err_rd_ev, intf_rd_ev;
  logic [4:0] txf_cnt;
  logic txf_ext;
  logic [3:0] txf_dlc;
  logic [IDX_W-1:0] pay_idx;

  assign op_now     = (byte_idx == '0) ? (core_ready ? rx_byte : 8'h00) : op_q;
  assign is_first   = byte_done && (byte_idx == '0);
  assign at_second  = byte_done && (byte_idx == IDX_W'(1));
  assign mreset_ev  = is_first && (op_now == OP_MRESET);
  assign err_rd_ev  = at_second && (op_q == OP_R_ERR);
  assign intf_rd_ev = at_second && (op_q == OP_R_IFLG);
  assign err_clr    = err_rd_ev  ? rd_snap : 8'h00;
  assign intf_clr   = intf_rd_ev ? rd_snap : 8'h00;
  assign pay_idx    = byte_idx - IDX_W'(1);
  assign irq        = |(intf_q & cfg_inte);

  always_comb begin
    case (op_now)
      OP_R_CTL0: read_val = cfg_ctrl0;
      OP_R_CTL1: read_val = cfg_ctrl1;
      OP_R_TIM0: read_val = cfg_btr0;
      OP_R_TIM1: read_val = cfg_btr1;
      OP_R_STAT: read_val = status_byte(tx_empty_q, rx_empty, bus_off, tec, rec);
      OP_R_IFLG: read_val = intf_q;
      OP_R_ERR:  read_val = err_q;
      OP_R_MSG:  read_val = msg_stat;
      OP_R_REC:  read_val = rec;
      OP_R_TEC:  read_val = tec;
      OP_R_RXF:  read_val = rx_empty ? 8'h00 : frame_byte(rx_head, 4'd0);
      default:   read_val = 8'h00;
    endcase
  end

  assign load_en = byte_done;
  always_comb begin
    if (byte_idx == '0)
      load_byte = read_val;
    else if (op_q == OP_R_RXF && rd_ok && byte_idx < IDX_LAST)
      load_byte = frame_byte(rx_head, 4'(byte_idx));
    else
      load_byte = 8'h00;
  end

  assign rx_pop     = byte_done && (op_q == OP_R_RXF) && rd_ok && (byte_idx == IDX_LAST);
  assign txf_valid  = byte_done && (op_q == OP_W_TXF) && (byte_idx != '0);
  assign txf_data   = rx_byte;
  assign txf_end    = cs_stop && cs_clean && (op_q == OP_W_TXF) && (txf_cnt != '0);
  assign txf_len_ok = (txf_cnt == tx_len_expect(txf_ext, txf_dlc));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= 8'h00;
      rd_snap <= 8'h00;
      rd_ok   <= 1'b0;
      txf_cnt <= '0;
      txf_ext <= 1'b0;
      txf_dlc <= '0;
    end else if (cs_stop) begin
      op_q    <= 8'h00;
      rd_ok   <= 1'b0;
      txf_cnt <= '0;
      txf_ext <= 1'b0;
      txf_dlc <= '0;
    end else begin
      if (is_first) begin
        op_q    <= op_now;
        rd_snap <= read_val;
        rd_ok   <= (op_now == OP_R_RXF) && !rx_empty;
      end
      if (txf_valid) begin
        if (txf_cnt != 5'h1F) txf_cnt <= txf_cnt + 1'b1;
        if (pay_idx == IDX_W'(2)) txf_ext <= rx_byte[3];
        if ((!txf_ext && pay_idx == IDX_W'(3)) || (txf_ext && pay_idx == IDX_W'(5)))
          txf_dlc <= rx_byte[3:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_ctrl0  <= CTL0_INIT;
      cfg_ctrl1  <= 8'h00;
      cfg_inte   <= 8'h00;
      cfg_btr0   <= 8'h00;
      cfg_btr1   <= 8'h00;
      intf_q     <= 8'h00;
      err_q      <= 8'h00;
      tx_empty_q <= 1'b1;
    end else begin
      if (mreset_ev) begin
        cfg_ctrl0 <= CTL0_INIT;
        cfg_ctrl1 <= 8'h00;
        cfg_inte  <= 8'h00;
        cfg_btr0  <= 8'h00;
        cfg_btr1  <= 8'h00;
      end else if (at_second) begin
        case (op_q)
          OP_W_CTL0: cfg_ctrl0 <= rx_byte;
          OP_W_CTL1: cfg_ctrl1 <= rx_byte;
          OP_W_IEN:  cfg_inte  <= rx_byte;
          OP_W_TIM0: cfg_btr0  <= rx_byte;
          OP_W_TIM1: cfg_btr1  <= rx_byte;
          default: ;
        endcase
      end
      intf_q <= mreset_ev ? ev_flags : ((intf_q & ~intf_clr) | ev_flags);
      err_q  <= (err_q & ~err_clr) | ev_err;
      if (mreset_ev || tx_sent) tx_empty_q <= 1'b1;
      else if (txf_end)         tx_empty_q <= 1'b0;
    end
  end

  // R4
  mode_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreset_ev |=> (cfg_ctrl0 == CTL0_INIT && cfg_inte == 8'h00));
  // R4
  err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mreset_ev && ev_err == 8'h00 && !err_rd_ev) |=> (err_q == $past(err_q)));
  // R5
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_rd_ev && ev_err == 8'h00) |=> ((err_q & $past(rd_snap)) == 8'h00));
  // R6
  intf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intf_rd_ev && ev_flags == 8'h00) |=> ((intf_q & $past(rd_snap)) == 8'h00));
  // R9
  tx_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txf_end && !tx_sent && !mreset_ev) |=> !tx_empty_q);
  // R10
  no_half_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txf_end |-> !byte_done);
endmodule

// File: rtl/can_spi_frontend.sv
module can_spi_frontend
  import can_spi_pkg::*;
#(
  parameter int RX_DEPTH = 4,
  parameter int IDX_W    = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  core_ready,
  input  logic                  spi_sclk,
  input  logic                  spi_cs_n,
  input  logic                  spi_mosi,
  output logic                  spi_miso,
  output logic [7:0]            cfg_ctrl0,
  output logic [7:0]            cfg_ctrl1,
  output logic [7:0]            cfg_inte,
  output logic [7:0]            cfg_btr0,
  output logic [7:0]            cfg_btr1,
  output logic                  cfg_tx_en,
  output logic                  irq,
  output logic                  txf_valid,
  output logic [7:0]            txf_data,
  output logic                  txf_end,
  output logic                  txf_len_ok,
  input  logic                  tx_sent,
  input  logic [7:0]            ev_flags,
  input  logic [7:0]            ev_err,
  input  logic                  bus_off,
  input  logic [7:0]            tec,
  input  logic [7:0]            rec,
  input  logic [7:0]            msg_stat,
  input  logic                  rx_push,
  input  logic [FRAME_BITS-1:0] rx_frame,
  output logic                  rx_full
);
  logic cs_stop, cs_clean, byte_done, load_en, rx_pop, rx_empty, mreset_ev;
  logic [7:0] rx_byte, load_byte;
  logic [IDX_W-1:0] byte_idx;
  logic [FRAME_BITS-1:0] rx_head;

  assign cfg_tx_en = cfg_ctrl1[7];

  can_spi_link #(.W(BYTE_W), .IDX_W(IDX_W)) u_link (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .miso(spi_miso), .cs_stop(cs_stop), .cs_clean(cs_clean), .byte_done(byte_done),
    .rx_byte(rx_byte), .byte_idx(byte_idx), .load_en(load_en), .load_byte(load_byte)
  );

  can_spi_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .core_ready(core_ready), .byte_done(byte_done),
    .rx_byte(rx_byte), .byte_idx(byte_idx), .cs_stop(cs_stop), .cs_clean(cs_clean),
    .load_en(load_en), .load_byte(load_byte), .cfg_ctrl0(cfg_ctrl0), .cfg_ctrl1(cfg_ctrl1),
    .cfg_inte(cfg_inte), .cfg_btr0(cfg_btr0), .cfg_btr1(cfg_btr1), .irq(irq),
    .txf_valid(txf_valid), .txf_data(txf_data), .txf_end(txf_end), .txf_len_ok(txf_len_ok),
    .tx_sent(tx_sent), .ev_flags(ev_flags), .ev_err(ev_err), .bus_off(bus_off),
    .tec(tec), .rec(rec), .msg_stat(msg_stat), .rx_head(rx_head), .rx_empty(rx_empty),
    .rx_pop(rx_pop), .mreset_ev(mreset_ev)
  );

  can_rx_store #(.DEPTH(RX_DEPTH), .FRAME_W(FRAME_BITS)) u_store (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_frame), .pop(rx_pop),
    .flush(mreset_ev), .head(rx_head), .empty(rx_empty), .full(rx_full)
  );
endmodule

// File: tb/can_spi_frontend_tb.sv
module can_spi_frontend_tb;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0, core_ready = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, miso;
  logic [7:0] cfg_ctrl0, cfg_ctrl1, cfg_inte, cfg_btr0, cfg_btr1;
  logic cfg_tx_en, irq, txf_valid, txf_end, txf_len_ok, rx_full;
  logic [7:0] txf_data;
  logic tx_sent = 1'b0, bus_off = 1'b0, rx_push = 1'b0;
  logic [7:0] ev_flags = 8'h00, ev_err = 8'h00, tec = 8'h00, rec = 8'h00, msg_stat = 8'h00;
  logic [111:0] rx_frame = '0;

  logic [7:0] tb_tx [16];
  logic [7:0] tb_rx [16];
  int vectors = 0, errors = 0;
  int txv_n = 0, txe_n = 0;
  logic [7:0] txv_last = 8'h00;
  logic txe_ok = 1'b0;

  always #2.5 clk = ~clk;

  can_spi_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .core_ready(core_ready), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .cfg_ctrl0(cfg_ctrl0), .cfg_ctrl1(cfg_ctrl1),
    .cfg_inte(cfg_inte), .cfg_btr0(cfg_btr0), .cfg_btr1(cfg_btr1), .cfg_tx_en(cfg_tx_en),
    .irq(irq), .txf_valid(txf_valid), .txf_data(txf_data), .txf_end(txf_end),
    .txf_len_ok(txf_len_ok), .tx_sent(tx_sent), .ev_flags(ev_flags), .ev_err(ev_err),
    .bus_off(bus_off), .tec(tec), .rec(rec), .msg_stat(msg_stat), .rx_push(rx_push),
    .rx_frame(rx_frame), .rx_full(rx_full)
  );

  always @(posedge clk) begin
    if (txf_valid) begin txv_n <= txv_n + 1; txv_last <= txf_data; end
    if (txf_end)   begin txe_n <= txe_n + 1; txe_ok <= txf_len_ok; end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spi_run(input int nbytes, input int extra_bits);
    cs_n = 1'b0;
    cyc(HALF);
    for (int b = 0; b < nbytes; b++) begin
      for (int i = 7; i >= 0; i--) begin
        mosi = tb_tx[b][i];
        cyc(HALF);
        tb_rx[b][i] = miso;
        sclk = 1'b1;
        cyc(HALF);
        sclk = 1'b0;
      end
    end
    for (int i = 0; i < extra_bits; i++) begin
      mosi = 1'b1;
      cyc(HALF);
      sclk = 1'b1;
      cyc(HALF);
      sclk = 1'b0;
    end
    cyc(HALF);
    cs_n = 1'b1;
    cyc(4 * HALF);
  endtask

  task automatic rd(input logic [7:0] op, output logic [7:0] v);
    tb_tx[0] = op; tb_tx[1] = 8'h00;
    spi_run(2, 0);
    v = tb_rx[1];
  endtask

  task automatic wr(input logic [7:0] op, input logic [7:0] val);
    tb_tx[0] = op; tb_tx[1] = val;
    spi_run(2, 0);
  endtask

  task automatic pulse_err(input logic [7:0] v);
    @(negedge clk) ev_err = v;
    @(negedge clk) ev_err = 8'h00;
  endtask

  task automatic pulse_flags(input logic [7:0] v);
    @(negedge clk) ev_flags = v;
    @(negedge clk) ev_flags = 8'h00;
  endtask

  task automatic pulse_sent();
    @(negedge clk) tx_sent = 1'b1;
    @(negedge clk) tx_sent = 1'b0;
  endtask

  task automatic push_frame(input logic [7:0] base);
    for (int k = 0; k < 14; k++) rx_frame[111-8*k -: 8] = base + 8'(k);
    @(negedge clk) rx_push = 1'b1;
    @(negedge clk) rx_push = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(8'hD2, v); chk(v, 8'h80, "R1 ctrl0 reset (also R3 second byte)");
    rd(8'hE2, v); chk(v, 8'h82, "R1 status reset");
    rd(8'hD4, v); chk(v, 8'h00, "R1 ctrl1 reset");
    rd(8'hDC, v); chk(v, 8'h00, "R1 error reset");
    chk({7'b0, cfg_tx_en}, 8'h00, "R1 tx enable reset");
    chk({7'b0, miso}, 8'h00, "R3 miso idle");
  endtask

  task automatic t_cfg();
    logic [7:0] v;
    wr(8'h14, 8'hA5); rd(8'hD2, v); chk(v, 8'hA5, "R2 ctrl0");
    wr(8'h16, 8'h80); rd(8'hD4, v); chk(v, 8'h80, "R2 ctrl1");
    chk({7'b0, cfg_tx_en}, 8'h01, "R13 tx enable set");
    wr(8'h1C, 8'h3C); chk(cfg_inte, 8'h3C, "R2 inte port");
    wr(8'h18, 8'h41); rd(8'hD6, v); chk(v, 8'h41, "R2 btr0");
    wr(8'h1A, 8'h23); rd(8'hD8, v); chk(v, 8'h23, "R2 btr1");
    chk(cfg_btr0, 8'h41, "R2 btr0 port");
    wr(8'h16, 8'h7F); chk({7'b0, cfg_tx_en}, 8'h00, "R13 tx enable clear");
  endtask

  task automatic t_unknown();
    logic [7:0] v;
    rd(8'h77, v); chk(v, 8'h00, "R11 unknown shifts zero");
    tb_tx[0] = 8'h77; tb_tx[1] = 8'h99; spi_run(2, 0);
    rd(8'hD2, v); chk(v, 8'hA5, "R11 no state change");
  endtask

  task automatic t_abort();
    logic [7:0] v;
    tb_tx[0] = 8'h14; spi_run(1, 4);
    rd(8'hD2, v); chk(v, 8'hA5, "R10 partial write dropped");
    pulse_err(8'h04);
    tb_tx[0] = 8'hDC; spi_run(1, 5);
    rd(8'hDC, v); chk(v, 8'h04, "R10 partial read does not clear");
    rd(8'hDC, v); chk(v, 8'h00, "R5 cleared after full read");
  endtask

  task automatic t_mreset();
    logic [7:0] v;
    pulse_err(8'h12);
    tb_tx[0] = 8'h56; spi_run(1, 0);
    rd(8'hD2, v); chk(v, 8'h80, "R4 mode init");
    chk(cfg_btr1, 8'h00, "R4 btr1 cleared");
    chk(cfg_inte, 8'h00, "R4 inte cleared");
    rd(8'hDC, v); chk(v, 8'h12, "R4 error flags kept");
    pulse_err(8'h01);
    rd(8'hDC, v); chk(v, 8'h01, "R5 only unread bit left");
    rd(8'hDC, v); chk(v, 8'h00, "R5 clear on read");
  endtask

  task automatic t_notready();
    logic [7:0] v;
    core_ready = 1'b0;
    wr(8'h14, 8'h33);
    rd(8'hD2, v); chk(v, 8'h00, "R12 read while not ready");
    core_ready = 1'b1;
    rd(8'hD2, v); chk(v, 8'h80, "R12 write ignored");
  endtask

  task automatic t_intf();
    logic [7:0] v;
    wr(8'h1C, 8'h20);
    pulse_flags(8'h01); cyc(2);
    chk({7'b0, irq}, 8'h00, "R6 masked flag no irq");
    pulse_flags(8'h20); cyc(2);
    chk({7'b0, irq}, 8'h01, "R6 irq raised");
    rd(8'hDE, v); chk(v, 8'h21, "R6 flags read");
    chk({7'b0, irq}, 8'h00, "R6 irq cleared");
    rd(8'hDE, v); chk(v, 8'h00, "R6 flags cleared");
  endtask

  task automatic t_status();
    logic [7:0] v;
    tec = 8'd100; rd(8'hE2, v); chk(v, 8'h92, "R7 warning");
    tec = 8'd10; rec = 8'd130; rd(8'hE2, v); chk(v, 8'h9A, "R7 passive");
    bus_off = 1'b1; rd(8'hE2, v); chk(v, 8'h9E, "R7 bus off");
    bus_off = 1'b0; tec = 8'h00; rec = 8'h00;
    rd(8'hE2, v); chk(v, 8'h82, "R7 back to idle");
  endtask

  task automatic t_counters();
    logic [7:0] v;
    tec = 8'h21; rec = 8'h42; msg_stat = 8'h5A;
    rd(8'hEC, v); chk(v, 8'h21, "R14 tec");
    rd(8'hEA, v); chk(v, 8'h42, "R14 rec");
    rd(8'hDA, v); chk(v, 8'h5A, "R14 msg status");
    tec = 8'h00; rec = 8'h00;
  endtask

  task automatic t_rxread();
    logic [7:0] v;
    push_frame(8'h10);
    push_frame(8'h40);
    rd(8'hE2, v); chk(v, 8'h80, "R7 rx not empty");
    tb_tx[0] = 8'h48;
    for (int k = 1; k < 16; k++) tb_tx[k] = 8'h00;
    spi_run(6, 0);
    chk(tb_rx[5], 8'h14, "R8 partial read bytes");
    spi_run(15, 0);
    chk(tb_rx[1], 8'h10, "R8 first frame byte 0 kept");
    chk(tb_rx[14], 8'h1D, "R8 first frame byte 13");
    spi_run(15, 0);
    chk(tb_rx[1], 8'h40, "R8 second frame byte 0");
    chk(tb_rx[9], 8'h48, "R8 second frame byte 8");
    rd(8'hE2, v); chk(v, 8'h82, "R8 store empty");
    spi_run(15, 0);
    chk(tb_rx[7], 8'h00, "R8 empty read zero");
  endtask

  task automatic t_txfifo();
    logic [7:0] v;
    int n0, e0;
    n0 = txv_n; e0 = txe_n;
    tb_tx[0] = 8'h12; tb_tx[1] = 8'h00; tb_tx[2] = 8'hAB; tb_tx[3] = 8'hC0;
    tb_tx[4] = 8'h03; tb_tx[5] = 8'hD1; tb_tx[6] = 8'hD2; tb_tx[7] = 8'hD3;
    spi_run(8, 0);
    chk(8'(txv_n - n0), 8'd7, "R9 std byte count");
    chk(txv_last, 8'hD3, "R9 last byte");
    chk(8'(txe_n - e0), 8'd1, "R9 end pulse");
    chk({7'b0, txe_ok}, 8'h01, "R9 std length ok");
    rd(8'hE2, v); chk(v, 8'h02, "R9 tx empty cleared");
    pulse_sent();
    rd(8'hE2, v); chk(v, 8'h82, "R9 tx sent sets empty");
    tb_tx[0] = 8'h12; tb_tx[1] = 8'h00; tb_tx[2] = 8'h01; tb_tx[3] = 8'h18;
    tb_tx[4] = 8'h02; tb_tx[5] = 8'h03; tb_tx[6] = 8'h02; tb_tx[7] = 8'hE1; tb_tx[8] = 8'hE2;
    spi_run(9, 0);
    chk({7'b0, txe_ok}, 8'h01, "R9 ext length ok");
    tb_tx[0] = 8'h12; tb_tx[1] = 8'h00; tb_tx[2] = 8'hAB; tb_tx[3] = 8'hC0;
    tb_tx[4] = 8'h03; tb_tx[5] = 8'hD1; tb_tx[6] = 8'hD2;
    spi_run(7, 0);
    chk({7'b0, txe_ok}, 8'h00, "R9 short frame flagged");
    chk(8'(txe_n - e0), 8'd3, "R9 end count");
    pulse_sent();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(5);
    t_reset();
    t_cfg();
    t_unknown();
    t_abort();
    t_mreset();
    t_notready();
    t_intf();
    t_status();
    t_counters();
    t_rxread();
    t_txfifo();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule